// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management master for the two-wire PHY management bus. Software packs a complete 32-bit management frame (start code, opcode, PHY address, register address, turnaround and write data) into a single command word and writes it to the block. That write launches one transaction. The block first sends a run of idle-high preamble bits and then shifts the command word out on the data pin, most significant bit first, against a management clock that it generates itself.

For a read, the block releases the data pin at the point where the PHY takes it over. It then collects the sixteen returned bits and puts them in the low half of the command register. At the end of every frame a sticky completion flag is set, and software clears it by writing a one. An interrupt output is the flag gated by a mask bit. A divisor register sets the management clock. The clock stays high for the divisor value in system cycles and then low for the same count. A divisor of zero freezes the transaction.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write to the command register (address 0) while idle starts a frame. The data pin drives 32 one bits and then the command word from bit 31 down to bit 0, one bit per management clock period. Each bit changes on the falling edge of the management clock.
- R2: The divisor field sits in bits 6:1 of the speed register (address 1). With divisor S, the management clock stays high for S system cycles and low for S cycles, and a frame lasts 128*S cycles.
- R3: While the divisor is zero, a started frame makes no progress and the management clock stays low. It resumes once a non-zero divisor is written.
- R4: When command bits 29:28 equal 2'b10 (read), output enable is low from the bit-16 slot to the end of the frame. The pin is sampled on each rising management clock edge of the last 16 slots. After completion, bits 15:0 of the command register hold the sampled value and bits 31:16 are unchanged.
- R5: A read addressed to a PHY that does not drive the line returns 16'hFFFF.
- R6: At the final falling edge the frame ends: busy clears and event bit 23 (address 2) sets. Writing 1 to bit 23 clears it. Writing 0 there leaves it set.
- R7: The interrupt output equals event bit 23 AND mask bit 23 (address 3). With the mask at zero the interrupt never asserts.
- R8: Busy reads as bit 0 of the event register. A command write that arrives while busy is ignored and leaves the command register unchanged.
- R9: For a write frame (any opcode other than 2'b10), output enable stays high for the whole frame and the command register keeps the written word.
- R10: After reset the clock and output enable are low, the data output is high, and all four registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 speed, 2 event, 3 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
Two cases are hard to reach from the ports. The first is a command write landing in the middle of a frame, which must leave both the running frame and the stored word untouched. The bench issues a second command write while a slow frame is still shifting, reads the command register back during that frame, and lets the cycle-by-cycle model confirm that the pin sequence is undisturbed. The second is the stalled frame under a zero divisor. The bench starts a frame with the divisor still zero, waits, checks that busy holds and the clock is low, and only then writes a divisor. The frame must then complete from its first bit with correct read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      SEL_CMD   = 2'd0,
      SEL_SPEED = 2'd1,
      SEL_EVENT = 2'd2,
      SEL_MASK  = 2'd3
   } reg_sel_e;

   localparam int EVT_DONE_BIT = 23;
   localparam int BUSY_BIT     = 0;
   localparam int SPEED_LSB    = 1;
   localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic [DIV_W-1:0] cnt;
   logic             mdc_q;
   logic             tick;

   assign tick     = run && (div != '0) && (cnt == div - 1'b1);
   assign rise_stb = tick && !mdc_q;
   assign fall_stb = tick && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (div != '0) begin
         if (tick) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
   parameter int PRE_LEN = 32,
   parameter int CMD_W   = 32,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              is_read,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data
);
   import mdio_pkg::*;

   localparam int FRAME_LEN = PRE_LEN + CMD_W;
   localparam int HDR_W     = CMD_W - DATA_W;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + HDR_W - 1);
   localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(PRE_LEN + HDR_W);

   logic              busy_q;
   logic [IDX_W-1:0]  idx;
   logic [CMD_W-1:0]  shreg;
   logic              read_q;
   logic [DATA_W-1:0] cap;
   logic              pre_phase;
   logic              cur_bit;

   generate
      if (PRE_LEN > 0) begin : g_pre
         localparam logic [IDX_W-1:0] PRE_END = IDX_W'(PRE_LEN);
         assign pre_phase = idx < PRE_END;
      end else begin : g_nopre
         assign pre_phase = 1'b0;
      end
   endgenerate

   assign cur_bit = pre_phase ? 1'b1 : shreg[CMD_W-1];
   assign done    = busy_q && fall_stb && (idx == LAST_IDX);
   assign busy    = busy_q;
   assign is_read = read_q;
   assign mdio_oe = busy_q && !(read_q && idx >= REL_IDX);
   assign mdio_o  = mdio_oe ? cur_bit : 1'b1;
   assign rd_data = cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx    <= '0;
         shreg  <= '0;
         read_q <= 1'b0;
         cap    <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx    <= '0;
         shreg  <= cmd_word;
         read_q <= (cmd_word[CMD_W-3 -: 2] == OP_READ);
         cap    <= '0;
      end else if (busy_q) begin
         if (rise_stb && idx >= CAP_IDX)
            cap <= {cap[DATA_W-2:0], mdio_i};
         if (fall_stb) begin
            if (idx == LAST_IDX) begin
               busy_q <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
               if (!pre_phase)
                  shreg <= shreg << 1;
            end
         end
      end
   end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
   parameter int CMD_W  = 32,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [CMD_W-1:0]  reg_wdata,
   input  logic              busy,
   input  logic              done,
   input  logic              is_read,
   input  logic [DATA_W-1:0] rd_data,
   output logic              start,
   output logic [CMD_W-1:0]  cmd_word,
   output logic [DIV_W-1:0]  div_val,
   output logic              evt_flag,
   output logic              mask_en,
   output logic [CMD_W-1:0]  reg_rdata,
   output logic              irq
);
   import mdio_pkg::*;

   logic [CMD_W-1:0] cmd_q;
   logic [DIV_W-1:0] div_q;
   logic             evt_q;
   logic             mask_q;
   reg_sel_e         sel;

   assign sel      = reg_sel_e'(reg_addr);
   assign start    = reg_wr && (sel == SEL_CMD) && !busy;
   assign cmd_word = cmd_q;
   assign div_val  = div_q;
   assign evt_flag = evt_q;
   assign mask_en  = mask_q;
   assign irq      = evt_q && mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         div_q  <= '0;
         evt_q  <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (start)
            cmd_q <= reg_wdata;
         else if (done && is_read)
            cmd_q[DATA_W-1:0] <= rd_data;

         if (reg_wr && sel == SEL_SPEED)
            div_q <= reg_wdata[SPEED_LSB +: DIV_W];

         if (done)
            evt_q <= 1'b1;
         else if (reg_wr && sel == SEL_EVENT && reg_wdata[EVT_DONE_BIT])
            evt_q <= 1'b0;

         if (reg_wr && sel == SEL_MASK)
            mask_q <= reg_wdata[EVT_DONE_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CMD:   reg_rdata = cmd_q;
         SEL_SPEED: reg_rdata[SPEED_LSB +: DIV_W] = div_q;
         SEL_EVENT: begin
            reg_rdata[EVT_DONE_BIT] = evt_q;
            reg_rdata[BUSY_BIT]     = busy;
         end
         SEL_MASK:  reg_rdata[EVT_DONE_BIT] = mask_q;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
   parameter int PRE_LEN = 32,
   parameter int CMD_W   = 32,
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [CMD_W-1:0] reg_wdata,
   output logic [CMD_W-1:0] reg_rdata,
   output logic             irq,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   import mdio_pkg::*;

   generate
      if (CMD_W <= EVT_DONE_BIT) begin : g_bad_cmd_w
         $error("CMD_W must exceed the event bit position");
      end
      if (DATA_W < 2 || DATA_W >= CMD_W - 4) begin : g_bad_data_w
         $error("DATA_W must leave room for the frame header");
      end
      if (DIV_W < 1 || DIV_W + SPEED_LSB > CMD_W) begin : g_bad_div_w
         $error("DIV_W does not fit the speed register");
      end
      if (PRE_LEN < 0) begin : g_bad_pre
         $error("PRE_LEN must not be negative");
      end
   endgenerate

   logic              start;
   logic              busy;
   logic              frame_done;
   logic              rd_op;
   logic              evt_flag;
   logic              mask_en;
   logic              rise_stb;
   logic              fall_stb;
   logic [CMD_W-1:0]  cmd_word;
   logic [DIV_W-1:0]  div_val;
   logic [DATA_W-1:0] rd_data;

   mdio_regs #(.CMD_W(CMD_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .busy(busy), .done(frame_done), .is_read(rd_op),
      .rd_data(rd_data), .start(start), .cmd_word(cmd_word), .div_val(div_val),
      .evt_flag(evt_flag), .mask_en(mask_en), .reg_rdata(reg_rdata), .irq(irq)
   );

   mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_val),
      .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_frame #(.PRE_LEN(PRE_LEN), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(reg_wdata),
      .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
      .busy(busy), .done(frame_done), .is_read(rd_op),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
   );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
   parameter int CMD_W = 32,
   parameter int DIV_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic             irq,
   input logic             mdc,
   input logic             mdio_oe,
   input logic             busy,
   input logic             frame_done,
   input logic             rd_op,
   input logic             evt_flag,
   input logic             mask_en,
   input logic [CMD_W-1:0] cmd_word,
   input logic [DIV_W-1:0] div_val
);
   p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && div_val == '0) |=> $stable(mdc));

   p_done_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (evt_flag && !busy));

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_en |-> !irq);

   p_release_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mdio_oe) |-> rd_op);

   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == 2'd0 && !frame_done) |=> $stable(cmd_word));

   p_write_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_op) |-> mdio_oe);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.CMD_W(CMD_W), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .irq(irq),
   .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy), .frame_done(frame_done),
   .rd_op(rd_op), .evt_flag(evt_flag), .mask_en(mask_en),
   .cmd_word(cmd_word), .div_val(div_val)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] PHY_ADDR = 5'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, mdc, mdio_o, mdio_oe, mdio_i;
   logic        phy_drv = 1'b0;
   logic        phy_val = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

   mdio_mgmt_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   function automatic logic [15:0] phy_data(input logic [4:0] r);
      return {3'b101, r, 3'b011, r};
   endfunction

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] r, input logic [15:0] d);
      return {2'b01, op, phy, r, 2'b10, d};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural PHY responder
   int          ph_f = -1;
   int          ph_ones = 0;
   logic [13:0] ph_hdr = '0;
   bit          ph_resp = 0;

   always @(posedge mdc) begin
      if (ph_f < 0) begin
         if (mdio_i) ph_ones++;
         else begin
            if (ph_ones >= 32) begin ph_f = 1; ph_hdr = '0; end
            ph_ones = 0;
         end
      end else begin
         if (ph_f < 14) ph_hdr = {ph_hdr[12:0], mdio_i};
         ph_f++;
         if (ph_f == 14)
            ph_resp = (ph_hdr[11:10] == 2'b10) && (ph_hdr[9:5] == PHY_ADDR);
         if (ph_f == 32) begin ph_f = -1; ph_resp = 0; ph_ones = 0; end
      end
   end

   always @(negedge mdc) begin
      if (ph_resp && ph_f >= 15 && ph_f <= 31) begin
         phy_drv <= 1'b1;
         phy_val <= (ph_f == 15) ? 1'b0 : phy_data(ph_hdr[4:0])[31-ph_f];
      end else begin
         phy_drv <= 1'b0;
         phy_val <= 1'b1;
      end
   end

   // cycle-by-cycle reference model
   bit          armed = 0;
   bit          m_busy = 0, m_evt = 0, m_mask = 0, m_b0 = 0, m_fin = 0;
   int          m_c = 0, m_spd = 0;
   logic [31:0] m_cmd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         armed = 1; m_busy = 0; m_evt = 0; m_mask = 0; m_c = 0; m_spd = 0; m_cmd = '0;
      end else begin
         m_b0 = m_busy; m_fin = 0;
         if (m_busy && m_spd != 0) begin
            m_c++;
            if (m_c == 128 * m_spd) m_fin = 1;
         end
         if (m_fin) begin
            m_busy = 0; m_evt = 1;
            if (m_cmd[29:28] == 2'b10)
               m_cmd[15:0] = (m_cmd[27:23] == PHY_ADDR) ? phy_data(m_cmd[22:18]) : 16'hFFFF;
         end else if (reg_wr && reg_addr == 2'd2 && reg_wdata[23]) m_evt = 0;
         if (reg_wr && reg_addr == 2'd0 && !m_b0) begin
            m_busy = 1; m_c = 0; m_cmd = reg_wdata;
         end
         if (reg_wr && reg_addr == 2'd1) m_spd = int'(reg_wdata[6:1]);
         if (reg_wr && reg_addr == 2'd3) m_mask = reg_wdata[23];
      end
   end

   always @(negedge clk) begin
      if (armed && !finished) begin
         int k; logic e_mdc, e_oe, e_o, bitv, rd;
         if (!m_busy) begin
            e_mdc = 0; e_oe = 0; e_o = 1;
         end else begin
            if (m_spd == 0) begin e_mdc = 0; k = 0; end
            else begin e_mdc = ((m_c / m_spd) % 2) == 1; k = m_c / (2 * m_spd); end
            bitv = (k < 32) ? 1'b1 : m_cmd[63-k];
            rd   = (m_cmd[29:28] == 2'b10);
            e_oe = !(rd && k >= 47);
            e_o  = e_oe ? bitv : 1'b1;
         end
         chk({31'd0, mdc}, {31'd0, e_mdc}, "R2 mdc");
         chk({31'd0, mdio_oe}, {31'd0, e_oe}, "R4 mdio_oe");
         chk({31'd0, mdio_o}, {31'd0, e_o}, "R1 mdio_o");
         chk({31'd0, irq}, {31'd0, m_evt & m_mask}, "R7 irq");
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd_reg(2'd2, v);
         if (!v[0]) return;
      end
      chk(32'd1, 32'd0, "R6 busy never cleared");
   endtask

   initial begin
      logic [31:0] v, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      rd_reg(2'd0, v); chk(v, 32'd0, "R10 cmd reg");
      rd_reg(2'd1, v); chk(v, 32'd0, "R10 speed reg");
      rd_reg(2'd2, v); chk(v, 32'd0, "R10 event reg");
      rd_reg(2'd3, v); chk(v, 32'd0, "R10 mask reg");
      chk({29'd0, mdc, mdio_oe, mdio_o}, 32'b001, "R10 pins");

      // R2 R4 read from responding PHY at divisor 1
      wr_reg(2'd1, 32'd1 << 1);
      rd_reg(2'd1, v); chk(v, 32'd2, "R2 speed readback");
      wr_reg(2'd3, 32'd1 << 23);
      c = mk(2'b10, PHY_ADDR, 5'd2, 16'h0000);
      wr_reg(2'd0, c);
      rd_reg(2'd2, v); chk({31'd0, v[0]}, 32'd1, "R8 busy bit set");
      wait_idle();
      rd_reg(2'd0, v); chk(v, {c[31:16], phy_data(5'd2)}, "R4 read data");
      rd_reg(2'd2, v); chk({31'd0, v[23]}, 32'd1, "R6 event set");
      chk({31'd0, irq}, 32'd1, "R7 irq on");
      wr_reg(2'd2, 32'h0000_0001);
      rd_reg(2'd2, v); chk({31'd0, v[23]}, 32'd1, "R6 zero write keeps flag");
      wr_reg(2'd2, 32'd1 << 23);
      rd_reg(2'd2, v); chk({31'd0, v[23]}, 32'd0, "R6 w1c clears");

      // R5 absent PHY
      c = mk(2'b10, 5'd7, 5'd9, 16'h0000);
      wr_reg(2'd0, c); wait_idle();
      rd_reg(2'd0, v); chk(v, {c[31:16], 16'hFFFF}, "R5 absent phy");
      wr_reg(2'd2, 32'd1 << 23);

      // R9 write frame, R8 ignored mid-frame command
      wr_reg(2'd1, 32'd3 << 1);
      c = mk(2'b01, PHY_ADDR, 5'd5, 16'h1234);
      wr_reg(2'd0, c);
      repeat (100) @(negedge clk);
      wr_reg(2'd0, mk(2'b10, 5'd1, 5'd1, 16'hBEEF));
      rd_reg(2'd0, v); chk(v, c, "R8 busy write ignored");
      wait_idle();
      rd_reg(2'd0, v); chk(v, c, "R9 write frame keeps word");

      // R7 masked interrupt
      wr_reg(2'd2, 32'd1 << 23);
      wr_reg(2'd3, 32'd0);
      wr_reg(2'd1, 32'd1 << 1);
      wr_reg(2'd0, mk(2'b01, 5'd0, 5'd0, 16'h00FF));
      wait_idle();
      rd_reg(2'd2, v); chk({31'd0, v[23]}, 32'd1, "R7 event while masked");
      chk({31'd0, irq}, 32'd0, "R7 irq masked");
      wr_reg(2'd2, 32'd1 << 23);

      // R3 stall with divisor zero, then resume
      wr_reg(2'd1, 32'd0);
      c = mk(2'b10, PHY_ADDR, 5'd31, 16'h0000);
      wr_reg(2'd0, c);
      repeat (20) @(negedge clk);
      rd_reg(2'd2, v); chk({31'd0, v[0]}, 32'd1, "R3 still busy");
      chk({31'd0, mdc}, 32'd0, "R3 mdc low");
      wr_reg(2'd1, 32'd2 << 1);
      wait_idle();
      rd_reg(2'd0, v); chk(v, {c[31:16], phy_data(5'd31)}, "R3 resumed read");

      repeat (5) @(negedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule